// File: doc/BRIEF.md
# Standard-Map Phase-Space Stepper

This block advances one point of the kicked-rotor standard map on the torus [0, 2π) × [0, 2π). It runs on a multi-cycle schedule. Angles and momenta are signed fixed-point words. A direction select picks the forward map, which applies a kick to the momentum and then drifts the angle. It can instead pick the exact inverse, which undoes the drift first and then removes the kick. Each step uses a single sine-table read and a single multiply. No division is needed in either direction.

A step starts at reset release from the seed point and later on each accepted trigger. The block then works through a short fixed sequence, followed by a reduction phase whose length grows with the kick strength. At the end it registers the new point and pulses `done`. It then holds that point until the next trigger. The point it holds is the starting point of the following step, so a controller that wants an orbit of N points gives N triggers.

Top module: `stdmap_stepper`

## Requirements
- R1: Every value is a 27-bit two's-complement word with 17 fraction bits. The period constant is 2π = 823550 (2π·2^17 rounded). Whenever `done` is high, both `x_out` and `p_out` are in [0, 823550).
- R2: A forward step (`inverse` = 0) gives p' = wrap(p + ((K·S(x)) >>> 17)) and x' = wrap(x + p'). Here `>>>` is an arithmetic (floor) shift of the full product, and wrap adds or subtracts 823550 until the value is in range.
- R3: An inverse step (`inverse` = 1) gives x' = wrap(x − p) and p' = wrap(p − ((K·S(x')) >>> 17)).
- R4: S(a) reads a table at address a[19:9] (3 integer and 8 fraction bits with the default table precision). Entry i holds sin(i/256)·2^17, rounded to the nearest integer.
- R5: While `rst_n` is low, `done` is 0 and `x_out`/`p_out` show `seed_x`/`seed_p`. After release the block runs one step from the seed, using the `kick` and `inverse` values present at release, and pulses `done` once.
- R6: `done` rises 3 + n clock edges after the edge that accepts a trigger. n ≥ 1 is the number of cycles the momentum reduction takes: one ±2π correction per cycle, and one cycle if the sum is already in range.
- R7: A `start` that arrives while a step is running is ignored. It does not change the result, the latency or the number of `done` pulses.
- R8: `done` is high for exactly one cycle per step. `x_out` and `p_out` change only together with a `done` pulse.
- R9: N forward steps followed by N inverse steps with the same K return exactly the starting point.
- R10: `kick` and `inverse` are captured on the accepting edge. Changes to them during a step have no effect on that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed point |
| start | input | 1 | Trigger for one step while idle |
| inverse | input | 1 | 0 = forward map, 1 = inverse map |
| kick | input | 27 | Signed kick strength K, 17 fraction bits |
| seed_x | input | 27 | Initial angle, in [0, 2π) |
| seed_p | input | 27 | Initial momentum, in [0, 2π) |
| x_out | output | 27 | Current angle |
| p_out | output | 27 | Current momentum |
| done | output | 1 | One-cycle pulse when a new point is registered |

## Verification
A wrong table entry, product shift or reduction decision shows up at the ports as a point that differs from the reference model. That difference is visible on the very `done` pulse that ends the faulty step. A reduction that stops early or runs long also moves the `done` edge away from the predicted 3 + n cycles. A sequencer that restarts on a stray trigger shows up as an extra pulse or a changed result. The round trip of forward and inverse steps magnifies any asymmetric error: a single wrong bit anywhere in the chain breaks the exact return to the seed.

// File: rtl/stdmap_pkg.sv
package stdmap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PREP = 3'd1,
      ST_KICK = 3'd2,
      ST_WRAP = 3'd3,
      ST_FIN  = 3'd4
   } step_st_e;

   localparam real TAU_REAL = 6.283185307179586;

endpackage

// File: rtl/stdmap_sine_rom.sv
module stdmap_sine_rom #(
   parameter int FRAC     = 17,
   parameter int LUT_FRAC = 8,
   parameter int SW       = FRAC + 2
) (
   input  logic [LUT_FRAC+2:0]   addr,
   output logic signed [SW-1:0]  val
);
   localparam int ABITS = LUT_FRAC + 3;
   localparam int DEPTH = 1 << ABITS;

   logic signed [SW-1:0] rom [DEPTH];

   // table contents are computed at elaboration: entry a = round(sin(a/2^LUT_FRAC)*2^FRAC)
   for (genvar a = 0; a < DEPTH; a++) begin : g_rom
      localparam int ENTRY = int'($sin(real'(a) / real'(2 ** LUT_FRAC)) * (2.0 ** FRAC));
      assign rom[a] = SW'(ENTRY);
   end

   assign val = rom[addr];

endmodule

// File: rtl/stdmap_kick_mul.sv
module stdmap_kick_mul #(
   parameter int W    = 27,
   parameter int SW   = 19,
   parameter int FRAC = 17,
   parameter int IW   = 28
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic signed [W-1:0]   k_i,
   input  logic signed [SW-1:0]  s_i,
   output logic signed [IW-1:0]  term
);
   localparam int PW = W + SW;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shd;

   assign prod = k_i * s_i;
   assign shd  = prod >>> FRAC;
   assign term = shd[IW-1:0];

   // R2: the scaled kick term fits the internal width without loss
   a_r2_term_fits: assert property (@(posedge clk) disable iff (!rst_n)
      shd == {{(PW-IW){term[IW-1]}}, term});

endmodule

// File: rtl/stdmap_wrap.sv
module stdmap_wrap #(
   parameter int IW = 28,
   parameter logic signed [IW-1:0] PERIOD = 823550
) (
   input  logic signed [IW-1:0] v,
   output logic signed [IW-1:0] adj,
   output logic                 adj_ok
);
   always_comb begin
      if (v < 0)
         adj = v + PERIOD;
      else if (v >= PERIOD)
         adj = v - PERIOD;
      else
         adj = v;
      adj_ok = (adj >= 0) && (adj < PERIOD);
   end

endmodule

// File: rtl/stdmap_stepper.sv
module stdmap_stepper
   import stdmap_pkg::*;
#(
   parameter int W        = 27,
   parameter int FRAC     = 17,
   parameter int LUT_FRAC = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 inverse,
   input  logic signed [W-1:0]  kick,
   input  logic signed [W-1:0]  seed_x,
   input  logic signed [W-1:0]  seed_p,
   output logic signed [W-1:0]  x_out,
   output logic signed [W-1:0]  p_out,
   output logic                 done
);
   localparam int IW = W + 1;
   localparam int SW = FRAC + 2;
   localparam int LO = FRAC - LUT_FRAC;
   localparam int HI = FRAC + 2;
   localparam logic signed [IW-1:0] TWO_PI  = IW'($rtoi(TAU_REAL * (2.0 ** FRAC) + 0.5));
   localparam logic signed [IW-1:0] FOUR_PI = TWO_PI + TWO_PI;

   if (LUT_FRAC < 1 || LUT_FRAC > FRAC) begin : g_bad_lut
      $error("stdmap_stepper: LUT_FRAC must lie in 1..FRAC");
   end
   if (W < FRAC + 4) begin : g_bad_width
      $error("stdmap_stepper: W too small to hold 2*pi and a sign");
   end

   step_st_e             st;
   logic signed [W-1:0]  x_q, p_q, ang, k_q;
   logic signed [IW-1:0] t;
   logic                 inv_q, done_q;

   logic signed [IW-1:0] x_ext, p_ext, ang_ext;
   logic signed [SW-1:0] sin_v;
   logic signed [IW-1:0] term;
   logic signed [IW-1:0] w0_adj, w1_in, w1_adj;
   logic                 w0_ok, w1_ok;

   assign x_ext   = {x_q[W-1], x_q};
   assign p_ext   = {p_q[W-1], p_q};
   assign ang_ext = {ang[W-1], ang};

   stdmap_sine_rom #(.FRAC(FRAC), .LUT_FRAC(LUT_FRAC), .SW(SW)) u_rom (
      .addr (ang[HI:LO]),
      .val  (sin_v)
   );

   stdmap_kick_mul #(.W(W), .SW(SW), .FRAC(FRAC), .IW(IW)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .k_i   (k_q),
      .s_i   (sin_v),
      .term  (term)
   );

   // multi-cycle reducer on the momentum term
   stdmap_wrap #(.IW(IW), .PERIOD(TWO_PI)) u_wrap_mom (
      .v      (t),
      .adj    (w0_adj),
      .adj_ok (w0_ok)
   );

   // single-cycle reducer: inverse drift in PREP, forward drift in FIN
   assign w1_in = (st == ST_PREP) ? (x_ext - p_ext) : (ang_ext + t);

   stdmap_wrap #(.IW(IW), .PERIOD(TWO_PI)) u_wrap_ang (
      .v      (w1_in),
      .adj    (w1_adj),
      .adj_ok (w1_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_PREP;
         x_q    <= seed_x;
         p_q    <= seed_p;
         k_q    <= kick;
         inv_q  <= inverse;
         ang    <= '0;
         t      <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  k_q   <= kick;
                  inv_q <= inverse;
                  st    <= ST_PREP;
               end
            end
            ST_PREP: begin
               ang <= inv_q ? w1_adj[W-1:0] : x_q;
               st  <= ST_KICK;
            end
            ST_KICK: begin
               t  <= inv_q ? (p_ext - term) : (p_ext + term);
               st <= ST_WRAP;
            end
            ST_WRAP: begin
               t <= w0_adj;
               if (w0_ok) st <= ST_FIN;
            end
            ST_FIN: begin
               x_q    <= inv_q ? ang : w1_adj[W-1:0];
               p_q    <= t[W-1:0];
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign x_out = x_q;
   assign p_out = p_q;
   assign done  = done_q;

   // R1: a registered point lies on the torus
   a_r1_out_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (x_ext >= 0 && x_ext < TWO_PI && p_ext >= 0 && p_ext < TWO_PI));

   // R2: forward drift sum needs only one correction
   a_r2_drift_span: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN && !inv_q) |-> (w1_in >= 0 && w1_in < FOUR_PI && w1_ok));

   // R3: inverse drift difference needs only one correction
   a_r3_undrift_span: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PREP && inv_q) |-> (w1_in > -TWO_PI && w1_in < TWO_PI && w1_ok));

   // R6: reduction exits as soon as the corrected term is in range
   a_r6_wrap_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WRAP && w0_ok) |=> (st == ST_FIN));

   // R7: a running step is never restarted
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && st != ST_FIN) |=> (st != ST_PREP && st != ST_IDLE));

   // R8: done is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: outputs move only with done
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(x_out) && $stable(p_out)));

   // R10: captured kick and direction hold during a step
   a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_KICK || st == ST_WRAP || st == ST_FIN) |-> ($stable(k_q) && $stable(inv_q)));

endmodule

// File: tb/sim_stdmap_stepper.sv
`timescale 1ns/1ps
module sim_stdmap_stepper;
   localparam int W        = 27;
   localparam int FRAC     = 17;
   localparam int LUT_FRAC = 8;
   localparam int LO       = FRAC - LUT_FRAC;
   localparam longint DEPTH = 2048;
   localparam longint TP   = 823550;
   localparam int NV       = 9;

   localparam logic        TD [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
   localparam longint      TK [NV] = '{65536, 131072, 131072, 655360, 655360, -262144, 6553600, 67043328, 0};
   localparam longint      TX [NV] = '{131072, 700000, 50000, 400000, 823549, 0, 300000, 123456, 411775};
   localparam longint      TPV[NV] = '{262144, 10000, 800000, 600000, 0, 823549, 500000, 654321, 411775};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic inverse = 1'b0;
   logic signed [W-1:0] kick = '0;
   logic signed [W-1:0] seed_x = '0;
   logic signed [W-1:0] seed_p = '0;
   logic signed [W-1:0] x_out, p_out;
   logic done;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   stdmap_stepper #(.W(W), .FRAC(FRAC), .LUT_FRAC(LUT_FRAC)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .inverse(inverse), .kick(kick),
      .seed_x(seed_x), .seed_p(seed_p), .x_out(x_out), .p_out(p_out), .done(done)
   );

   // ---------------- reference model from the requirements ----------------
   function automatic longint sinq(longint a);
      longint idx = (a >>> LO) & (DEPTH - 1);
      return longint'(int'($sin(real'(idx) / real'(2 ** LUT_FRAC)) * (2.0 ** FRAC)));
   endfunction

   function automatic longint kterm(longint k, longint a);
      return (k * sinq(a)) >>> FRAC;
   endfunction

   function automatic longint wrap1(longint v);
      if (v < 0) return v + TP;
      if (v >= TP) return v - TP;
      return v;
   endfunction

   task automatic model(input longint x, input longint p, input longint k, input logic d,
                        output longint nx, output longint np, output int nred);
      longint t, a;
      if (!d) begin
         t = p + kterm(k, x);
      end else begin
         a = wrap1(x - p);
         t = p - kterm(k, a);
      end
      nred = 1;
      t = wrap1(t);
      while (t < 0 || t >= TP) begin
         t = wrap1(t);
         nred++;
      end
      np = t;
      nx = d ? a : wrap1(x + t);
   endtask

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_done(output int lat);
      lat = 0;
      while (!done && lat < 3000) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
      end
   endtask

   task automatic reset_seed(input longint x, input longint p, input longint k, input logic d,
                             output int lat);
      @(negedge clk);
      rst_n = 1'b0; seed_x = x; seed_p = p; kick = k; inverse = d; start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 done low in reset", longint'(done), 0);
      chk("R5 x seed in reset", longint'(x_out), x);
      chk("R5 p seed in reset", longint'(p_out), p);
      rst_n = 1'b1;
      wait_done(lat);
   endtask

   task automatic trig(input longint k, input logic d, output int lat);
      @(negedge clk);
      kick = k; inverse = d; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      wait_done(lat);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      longint ex, ep, cx, cp;
      int nred, lat, extra;
      longint hx, hp;

      // ---------------- vector table walk ----------------
      for (int i = 0; i < NV; i++) begin
         reset_seed(TX[i], TPV[i], TK[i], TD[i], lat);
         model(TX[i], TPV[i], TK[i], TD[i], ex, ep, nred);
         chk("R5 reset step done", longint'(done), 1);
         chk("R5 reset step latency", lat, 3 + nred);
         chk(TD[i] ? "R3/R4 x after reset step" : "R2/R4 x after reset step", longint'(x_out), ex);
         chk(TD[i] ? "R3/R4 p after reset step" : "R2/R4 p after reset step", longint'(p_out), ep);
         cx = ex; cp = ep;
         trig(TK[i], TD[i], lat);
         model(cx, cp, TK[i], TD[i], ex, ep, nred);
         chk("R6 step latency", lat, 3 + nred);
         chk(TD[i] ? "R3 x triggered" : "R2 x triggered", longint'(x_out), ex);
         chk(TD[i] ? "R3 p triggered" : "R2 p triggered", longint'(p_out), ep);
         chk("R1 x in range", longint'(x_out >= 0 && x_out < TP), 1);
         chk("R1 p in range", longint'(p_out >= 0 && p_out < TP), 1);
         @(negedge clk);
         chk("R8 done one cycle", longint'(done), 0);
      end

      // ---------------- R4 directed: sine at zero angle leaves p unchanged ----------------
      reset_seed(0, 100000, 131072, 1'b0, lat);
      chk("R4 sin(0)=0 p", longint'(p_out), 100000);
      chk("R4 sin(0)=0 x", longint'(x_out), 100000);

      // ---------------- R7 / R10: trigger and input changes while busy ----------------
      reset_seed(250000, 450000, 655360, 1'b0, lat);
      cx = longint'(x_out); cp = longint'(p_out);
      model(cx, cp, 655360, 1'b0, ex, ep, nred);
      @(negedge clk);
      kick = 655360; inverse = 1'b0; start = 1'b1;
      @(posedge clk);
      lat = 0;
      while (!done && lat < 3000) begin
         @(negedge clk);
         if (lat < 3) begin
            start = 1'b1; kick = -6553600; inverse = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (done) break;
         @(posedge clk);
         lat++;
      end
      @(negedge clk);
      start = 1'b0;
      if (!done) wait_done(extra);
      chk("R7 latency with busy start", lat, 3 + nred);
      chk("R10 x ignores mid-step kick", longint'(x_out), ex);
      chk("R10 p ignores mid-step direction", longint'(p_out), ep);
      hx = longint'(x_out); hp = longint'(p_out);
      extra = 0;
      repeat (60) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk("R7 no extra done pulse", extra, 0);
      chk("R8 x held idle", longint'(x_out), hx);
      chk("R8 p held idle", longint'(p_out), hp);

      // ---------------- R9: forward N then inverse N returns to seed ----------------
      reset_seed(200000, 700000, 655360, 1'b0, lat);
      for (int s = 0; s < 5; s++) trig(655360, 1'b0, lat);
      for (int s = 0; s < 6; s++) trig(655360, 1'b1, lat);
      chk("R9 x round trip", longint'(x_out), 200000);
      chk("R9 p round trip", longint'(p_out), 700000);

      reset_seed(777777, 33333, 67043328, 1'b0, lat);
      for (int s = 0; s < 3; s++) trig(67043328, 1'b0, lat);
      for (int s = 0; s < 4; s++) trig(67043328, 1'b1, lat);
      chk("R9 x round trip large K", longint'(x_out), 777777);
      chk("R9 p round trip large K", longint'(p_out), 33333);

      summary();
      $finish;
   end

endmodule